// File: doc/BRIEF.md
# Two-Core MESI Coherence Controller

This block keeps the coherence state of every cache line that two cores hold in private caches over one shared memory. It stores no data. For each line and each core it records one of the four MESI states. It decides how both copies change when either core reads or writes, and it issues the flush and reload commands that memory must carry out before an access can complete.

Each core holds a request with a byte address and a write flag until it receives a one-cycle acknowledge that carries a hit flag. Memory commands wait on a ready handshake, and the requesting core is stalled until its command sequence ends. Three counters track hits, misses and coherence-induced reloads. A coherence-induced reload is a reload that needed the peer's Modified copy flushed first, which is the cost of false sharing. An observation port returns the states of any one line in both cores.

Top module: `mesi_dual_ctrl`

## Requirements
- R1: After reset, every line in both cores is Invalid and all three counters read zero. States are coded Invalid=00, Shared=01, Exclusive=10, Modified=11 on obs_state0/obs_state1 for the line on obs_line.
- R2: A read of a line that both cores hold Invalid issues one reload into the requester and no flush. It is a miss, and the requester ends Exclusive.
- R3: A read of an Invalid copy while the peer holds the line Exclusive or Shared issues one reload and no flush. It is a miss, and both copies end Shared.
- R4: A write to a copy that is Shared, Exclusive or Modified is a hit with no memory command. The writer ends Modified and the peer ends Invalid, so a Modified or Exclusive copy never coexists with a valid peer copy.
- R5: A read of a valid own copy is a hit with no memory command, leaves both states unchanged, and is acknowledged one cycle after the request is taken.
- R6: A read of an Invalid copy while the peer holds Modified first issues a flush from the peer's cache (mem_cmd_flush=1, mem_cmd_core = peer), then a reload into the requester (mem_cmd_flush=0, mem_cmd_core = requester). Both copies end Shared and fshare_count rises by one.
- R7: A write to an Invalid copy issues a reload into the writer and leaves the writer Modified and the peer Invalid. When the peer held Modified, a peer flush precedes the reload and fshare_count rises by one.
- R8: Coherence is tracked per 64-byte line. The line index is the byte address with its low 6 bits dropped, so accesses that differ only in those bits share state.
- R9: A memory command keeps its kind, core and line stable until mem_ready is seen. The requester is acknowledged one cycle after the final handshake and never while a command is pending.
- R10: When both cores present requests in the same cycle, core 0 is served first and core 1 in a later cycle. At most one acknowledge is high in any cycle.
- R11: hit_count rises by one for each hit and miss_count by one for each miss, in the cycle the request is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Core 0 request, held until c0_ack |
| c0_we | input | 1 | Core 0 write (1) or read (0) |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c0_ack | output | 1 | Core 0 request complete (one cycle) |
| c0_hit | output | 1 | Core 0 last request hit, valid with c0_ack |
| c1_req | input | 1 | Core 1 request, held until c1_ack |
| c1_we | input | 1 | Core 1 write (1) or read (0) |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c1_ack | output | 1 | Core 1 request complete (one cycle) |
| c1_hit | output | 1 | Core 1 last request hit, valid with c1_ack |
| mem_cmd_valid | output | 1 | Memory command pending |
| mem_cmd_flush | output | 1 | 1 = flush from a cache, 0 = reload into a cache |
| mem_cmd_core | output | 1 | Core whose cache the command concerns |
| mem_cmd_line | output | ADDR_W-6 | Line index of the command |
| mem_ready | input | 1 | Memory accepts the pending command |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |
| fshare_count | output | CNT_W | Number of reloads that forced a peer flush |
| obs_line | input | ADDR_W-6 | Line to observe |
| obs_state0 | output | 2 | Core 0 state of obs_line |
| obs_state1 | output | 2 | Core 1 state of obs_line |

## Verification
A hit is acknowledged, with its state change and counter step, one cycle after the edge that takes the request. A miss is acknowledged one cycle after the edge that completes its last memory handshake. The bench drives and samples on the falling edge. It expects a hit acknowledge on the first falling edge after the request and logs each handshake on the falling edge before the edge that will accept it. Only after an acknowledge does it read the observed states and the counters against its own model of the two caches, in a directed series followed by a long pseudo-random sweep over a few lines with varying memory latency.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  localparam int LINE_OFS = 6;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'b00,
    SQ_FLUSH  = 2'b01,
    SQ_RELOAD = 2'b10
  } seq_t;

  typedef struct packed {
    logic  hit;
    logic  flush;
    logic  reload;
    mesi_t own_nxt;
    mesi_t peer_nxt;
  } act_t;

  // Outcome of one access given the requester's and the peer's copy.
  function automatic act_t mesi_decide(input logic we, input mesi_t own, input mesi_t peer);
    act_t a;
    a.hit      = 1'b0;
    a.flush    = 1'b0;
    a.reload   = 1'b0;
    a.own_nxt  = own;
    a.peer_nxt = peer;
    if (!we) begin
      if (own != ST_I) begin
        a.hit = 1'b1;
      end else begin
        a.reload = 1'b1;
        a.flush  = (peer == ST_M);
        if (peer == ST_I) begin
          a.own_nxt = ST_E;
        end else begin
          a.own_nxt  = ST_S;
          a.peer_nxt = ST_S;
        end
      end
    end else begin
      a.own_nxt  = ST_M;
      a.peer_nxt = ST_I;
      if (own != ST_I) begin
        a.hit = 1'b1;
      end else begin
        a.reload = 1'b1;
        a.flush  = (peer == ST_M);
      end
    end
    return a;
  endfunction

endpackage

// File: rtl/mesi_state_table.sv
module mesi_state_table
  import mesi_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  mesi_t             wr_state,
  input  logic [LINE_W-1:0] rd_line,
  output mesi_t             rd_state,
  input  logic [LINE_W-1:0] obs_line,
  output mesi_t             obs_state
);
  localparam int NLINES = 1 << LINE_W;

  mesi_t st_q [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= ST_I;
    end else if (wr_en) begin
      st_q[wr_line] <= wr_state;
    end
  end

  assign rd_state  = st_q[rd_line];
  assign obs_state = st_q[obs_line];

endmodule

// File: rtl/mesi_arbiter.sv
module mesi_arbiter (
  input  logic busy,
  input  logic req0,
  input  logic req1,
  input  logic ack0,
  input  logic ack1,
  output logic grant0,
  output logic grant1
);
  logic elig0, elig1;

  // A request whose acknowledge is showing is already consumed.
  assign elig0  = req0 & ~ack0;
  assign elig1  = req1 & ~ack1;
  assign grant0 = ~busy & elig0;
  assign grant1 = ~busy & ~elig0 & elig1;

endmodule

// File: rtl/mesi_seq.sv
module mesi_seq
  import mesi_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant0,
  input  logic              grant1,
  input  logic              we_sel,
  input  logic [LINE_W-1:0] sel_line,
  input  mesi_t             own_st,
  input  mesi_t             peer_st,
  input  logic              mem_ready,
  output logic              busy,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_line,
  output mesi_t             wr_st0,
  output mesi_t             wr_st1,
  output logic              ack0,
  output logic              ack1,
  output logic              hit0,
  output logic              hit1,
  output logic              cmd_valid,
  output logic              cmd_flush,
  output logic              cmd_core,
  output logic [LINE_W-1:0] cmd_line,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_fshare
);
  seq_t              state;
  logic              cur_core;
  logic [LINE_W-1:0] cur_line;
  act_t              cur_act;
  act_t              act;
  act_t              use_act;
  logic              use_core;
  logic              granted;
  logic              done;

  assign granted = grant0 | grant1;
  assign act     = mesi_decide(we_sel, own_st, peer_st);
  assign done    = (state == SQ_RELOAD) && mem_ready;
  assign busy    = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cur_core <= 1'b0;
      cur_line <= '0;
      cur_act  <= '0;
      ack0     <= 1'b0;
      ack1     <= 1'b0;
      hit0     <= 1'b0;
      hit1     <= 1'b0;
    end else begin
      ack0 <= 1'b0;
      ack1 <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (granted) begin
            cur_core <= grant1;
            cur_line <= sel_line;
            cur_act  <= act;
            if (grant1) hit1 <= act.hit;
            else        hit0 <= act.hit;
            if (act.hit) begin
              if (grant1) ack1 <= 1'b1;
              else        ack0 <= 1'b1;
            end else begin
              state <= act.flush ? SQ_FLUSH : SQ_RELOAD;
            end
          end
        end
        SQ_FLUSH: begin
          if (mem_ready) state <= SQ_RELOAD;
        end
        SQ_RELOAD: begin
          if (mem_ready) begin
            state <= SQ_IDLE;
            if (cur_core) ack1 <= 1'b1;
            else          ack0 <= 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // Both tables are written in the same cycle so the pair stays consistent.
  always_comb begin
    use_act  = done ? cur_act : act;
    use_core = done ? cur_core : grant1;
    wr_en    = ((state == SQ_IDLE) && granted && act.hit) || done;
    wr_line  = done ? cur_line : sel_line;
    wr_st0   = use_core ? use_act.peer_nxt : use_act.own_nxt;
    wr_st1   = use_core ? use_act.own_nxt  : use_act.peer_nxt;
  end

  assign cmd_valid = busy;
  assign cmd_flush = (state == SQ_FLUSH);
  assign cmd_core  = cmd_flush ? ~cur_core : cur_core;
  assign cmd_line  = cur_line;

  assign ev_hit    = (state == SQ_IDLE) && granted && act.hit;
  assign ev_miss   = (state == SQ_IDLE) && granted && !act.hit;
  assign ev_fshare = done && cur_act.flush;

endmodule

// File: rtl/mesi_event_counters.sv
module mesi_event_counters #(
  parameter int N_EV  = 3,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_EV-1:0]            ev,
  output logic [N_EV-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)     cnt[g] <= '0;
      else if (ev[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end

endmodule

// File: rtl/mesi_dual_ctrl.sv
module mesi_dual_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     c0_req,
  input  logic                     c0_we,
  input  logic [ADDR_W-1:0]        c0_addr,
  output logic                     c0_ack,
  output logic                     c0_hit,
  input  logic                     c1_req,
  input  logic                     c1_we,
  input  logic [ADDR_W-1:0]        c1_addr,
  output logic                     c1_ack,
  output logic                     c1_hit,
  output logic                     mem_cmd_valid,
  output logic                     mem_cmd_flush,
  output logic                     mem_cmd_core,
  output logic [ADDR_W-LINE_OFS-1:0] mem_cmd_line,
  input  logic                     mem_ready,
  output logic [CNT_W-1:0]         hit_count,
  output logic [CNT_W-1:0]         miss_count,
  output logic [CNT_W-1:0]         fshare_count,
  input  logic [ADDR_W-LINE_OFS-1:0] obs_line,
  output logic [1:0]               obs_state0,
  output logic [1:0]               obs_state1
);
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int N_EV   = 3;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFS];
  endfunction

  logic              grant0, grant1, busy;
  logic [LINE_W-1:0] line0, line1, sel_line;
  logic              we_sel;
  mesi_t             rd_st  [2];
  mesi_t             obs_st [2];
  mesi_t             wr_st  [2];
  mesi_t             own_st, peer_st;
  logic              wr_en;
  logic [LINE_W-1:0] wr_line;
  logic              ev_hit, ev_miss, ev_fshare;
  logic [N_EV-1:0][CNT_W-1:0] cnt;

  assign line0    = line_of(c0_addr);
  assign line1    = line_of(c1_addr);
  assign sel_line = grant1 ? line1 : line0;
  assign we_sel   = grant1 ? c1_we : c0_we;
  assign own_st   = grant1 ? rd_st[1] : rd_st[0];
  assign peer_st  = grant1 ? rd_st[0] : rd_st[1];

  mesi_arbiter u_arb (
    .busy   (busy),
    .req0   (c0_req),
    .req1   (c1_req),
    .ack0   (c0_ack),
    .ack1   (c1_ack),
    .grant0 (grant0),
    .grant1 (grant1)
  );

  for (genvar g = 0; g < 2; g++) begin : g_core
    mesi_state_table #(.LINE_W(LINE_W)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_line   (wr_line),
      .wr_state  (wr_st[g]),
      .rd_line   (sel_line),
      .rd_state  (rd_st[g]),
      .obs_line  (obs_line),
      .obs_state (obs_st[g])
    );
  end

  mesi_seq #(.LINE_W(LINE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant0    (grant0),
    .grant1    (grant1),
    .we_sel    (we_sel),
    .sel_line  (sel_line),
    .own_st    (own_st),
    .peer_st   (peer_st),
    .mem_ready (mem_ready),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_line   (wr_line),
    .wr_st0    (wr_st[0]),
    .wr_st1    (wr_st[1]),
    .ack0      (c0_ack),
    .ack1      (c1_ack),
    .hit0      (c0_hit),
    .hit1      (c1_hit),
    .cmd_valid (mem_cmd_valid),
    .cmd_flush (mem_cmd_flush),
    .cmd_core  (mem_cmd_core),
    .cmd_line  (mem_cmd_line),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_fshare (ev_fshare)
  );

  mesi_event_counters #(.N_EV(N_EV), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    ({ev_fshare, ev_miss, ev_hit}),
    .cnt   (cnt)
  );

  assign hit_count    = cnt[0];
  assign miss_count   = cnt[1];
  assign fshare_count = cnt[2];
  assign obs_state0   = obs_st[0];
  assign obs_state1   = obs_st[1];

endmodule

// File: rtl/mesi_dual_ctrl_chk.sv
module mesi_dual_ctrl_chk #(
  parameter int LINE_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c0_ack,
  input logic              c1_ack,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_flush,
  input logic              mem_cmd_core,
  input logic [LINE_W-1:0] mem_cmd_line,
  input logic              mem_ready,
  input logic [1:0]        obs_state0,
  input logic [1:0]        obs_state1,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  fshare_count,
  input logic              ev_hit,
  input logic              ev_fshare
);
  // R9: a pending command holds until accepted
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_ready |=> mem_cmd_valid && $stable(mem_cmd_flush)
      && $stable(mem_cmd_core) && $stable(mem_cmd_line));

  // R9: no acknowledge while memory work is outstanding
  a_r9_no_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> !(c0_ack || c1_ack));

  // R10: one acknowledge at a time
  a_r10_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c0_ack, c1_ack}));

  // R6: an accepted flush is followed by a reload into the other cache
  a_r6_flush_then_reload: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_flush && mem_ready |=> mem_cmd_valid && !mem_cmd_flush
      && (mem_cmd_core != $past(mem_cmd_core)));

  // R4: an owned copy excludes any valid peer copy
  a_r4_owner0: assert property (@(posedge clk) disable iff (!rst_n)
    obs_state0[1] |-> obs_state1 == 2'b00);
  a_r4_owner1: assert property (@(posedge clk) disable iff (!rst_n)
    obs_state1[1] |-> obs_state0 == 2'b00);

  // R11: hit counter steps with each hit and holds otherwise
  a_r11_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> hit_count == $past(hit_count) + 1'b1);
  a_r11_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit |=> $stable(hit_count));

  // R6: false-sharing counter steps once per penalised reload
  a_r6_fshare_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fshare |=> fshare_count == $past(fshare_count) + 1'b1);

endmodule

bind mesi_dual_ctrl mesi_dual_ctrl_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .c0_ack        (c0_ack),
  .c1_ack        (c1_ack),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_flush (mem_cmd_flush),
  .mem_cmd_core  (mem_cmd_core),
  .mem_cmd_line  (mem_cmd_line),
  .mem_ready     (mem_ready),
  .obs_state0    (obs_state0),
  .obs_state1    (obs_state1),
  .hit_count     (hit_count),
  .fshare_count  (fshare_count),
  .ev_hit        (ev_hit),
  .ev_fshare     (ev_fshare)
);

// File: tb/tb_mesi_dual_ctrl.sv
module tb_mesi_dual_ctrl;
  localparam int ADDR_W = 10;
  localparam int LW     = 4;
  localparam int CW     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
  logic [ADDR_W-1:0] c0_addr = '0, c1_addr = '0;
  logic c0_ack, c0_hit, c1_ack, c1_hit;
  logic mem_cmd_valid, mem_cmd_flush, mem_cmd_core;
  logic [LW-1:0] mem_cmd_line;
  logic mem_ready = 1'b0;
  logic [CW-1:0] hit_count, miss_count, fshare_count;
  logic [LW-1:0] obs_line = '0;
  logic [1:0] obs_state0, obs_state1;

  always #4 clk = ~clk;

  mesi_dual_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .c0_req(c0_req), .c0_we(c0_we), .c0_addr(c0_addr), .c0_ack(c0_ack), .c0_hit(c0_hit),
    .c1_req(c1_req), .c1_we(c1_we), .c1_addr(c1_addr), .c1_ack(c1_ack), .c1_hit(c1_hit),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_flush(mem_cmd_flush), .mem_cmd_core(mem_cmd_core),
    .mem_cmd_line(mem_cmd_line), .mem_ready(mem_ready),
    .hit_count(hit_count), .miss_count(miss_count), .fshare_count(fshare_count),
    .obs_line(obs_line), .obs_state0(obs_state0), .obs_state1(obs_state1)
  );

  int checks = 0, failures = 0;
  int m_st [2][16];
  int m_hits = 0, m_miss = 0, m_fs = 0;

  // memory model and handshake log
  int  lat = 1, wcnt = 0;
  bit  hs_prev = 0;
  bit  ctx_on = 0;
  int  op_core = 0, op_line = 0;
  int  n_flush = 0, n_reload = 0;
  bit  flush_first = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hs_prev) begin
      mem_ready <= 1'b0; wcnt = 0; hs_prev = 0;
    end else if (mem_cmd_valid) begin
      wcnt++;
      if (wcnt >= lat) mem_ready <= 1'b1;
    end else begin
      mem_ready <= 1'b0; wcnt = 0;
    end
    #1;
    if (mem_cmd_valid && mem_ready) begin
      hs_prev = 1;
      if (mem_cmd_flush) begin
        n_flush++;
        if (ctx_on) chk(int'(mem_cmd_core) == 1 - op_core, "R6 flush core", mem_cmd_core, 1 - op_core);
      end else begin
        n_reload++;
        flush_first = (n_flush > 0);
        if (ctx_on) chk(int'(mem_cmd_core) == op_core, "R9 reload core", mem_cmd_core, op_core);
      end
      if (ctx_on) chk(int'(mem_cmd_line) == op_line, "R9 cmd line", mem_cmd_line, op_line);
    end
  end

  // Independent model: returns hit, flush needed, and a tag.
  task automatic model(input int core, input int we, input int line,
                       output bit hit, output bit fl, output string tag);
    int me, pe;
    me = m_st[core][line];
    pe = m_st[1-core][line];
    fl = 0;
    if (we == 1) begin
      hit = (me != 0);
      if (!hit && pe == 3) fl = 1;
      tag = hit ? "R4" : "R7";
      m_st[core][line] = 3;
      m_st[1-core][line] = 0;
    end else if (me != 0) begin
      hit = 1; tag = "R5";
    end else begin
      hit = 0;
      case (pe)
        0: begin m_st[core][line] = 2; tag = "R2"; end
        3: begin fl = 1; m_st[core][line] = 1; m_st[1-core][line] = 1; tag = "R6"; end
        default: begin m_st[core][line] = 1; m_st[1-core][line] = 1; tag = "R3"; end
      endcase
    end
    if (hit) m_hits++; else m_miss++;
    if (fl) m_fs++;
  endtask

  task automatic check_line(input int line, input string tag);
    obs_line = line[LW-1:0];
    #1;
    chk(int'(obs_state0) == m_st[0][line], {tag, " state core0"}, obs_state0, m_st[0][line]);
    chk(int'(obs_state1) == m_st[1][line], {tag, " state core1"}, obs_state1, m_st[1][line]);
  endtask

  task automatic check_counts(input string tag);
    chk(int'(hit_count) == m_hits, {tag, " R11 hits"}, hit_count, m_hits);
    chk(int'(miss_count) == m_miss, {tag, " R11 misses"}, miss_count, m_miss);
    chk(int'(fshare_count) == m_fs, {tag, " fshare"}, fshare_count, m_fs);
  endtask

  task automatic do_op(input int core, input int we, input int line, input int off);
    bit hit, fl, got;
    string tag;
    int cyc;
    model(core, we, line, hit, fl, tag);
    @(negedge clk);
    n_flush = 0; n_reload = 0; flush_first = 0;
    op_core = core; op_line = line; ctx_on = 1;
    if (core == 0) begin c0_req = 1; c0_we = we[0]; c0_addr = {line[LW-1:0], off[5:0]}; end
    else           begin c1_req = 1; c1_we = we[0]; c1_addr = {line[LW-1:0], off[5:0]}; end
    cyc = 0; got = 0;
    while (!got && cyc < 60) begin
      @(negedge clk);
      #2;
      cyc++;
      got = (core == 0) ? c0_ack : c1_ack;
    end
    c0_req = 0; c1_req = 0;
    ctx_on = 0;
    chk(got, {tag, " ack seen"}, got, 1);
    chk(((core == 0) ? c0_hit : c1_hit) == hit, {tag, " hit flag"}, (core == 0) ? c0_hit : c1_hit, hit);
    if (hit) chk(cyc == 1, {tag, " R5 hit latency"}, cyc, 1);
    chk(n_flush == int'(fl), {tag, " flush count"}, n_flush, fl);
    chk(n_reload == int'(!hit), {tag, " R9 reload count"}, n_reload, !hit);
    if (fl) chk(flush_first, {tag, " flush before reload"}, flush_first, 1);
    check_line(line, tag);
    check_counts(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int l = 0; l < 16; l++) m_st[c][l] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int l = 0; l < 16; l++) check_line(l, "R1");
    check_counts("R1");
    chk(!mem_cmd_valid && !c0_ack && !c1_ack, "R1 quiet", mem_cmd_valid, 0);

    // Four-step sharing story on line 3, then write penalty (R2 R3 R4 R6 R7 R5)
    do_op(0, 0, 3, 0);   // R2: E / I
    do_op(1, 0, 3, 8);   // R3: S / S
    do_op(1, 1, 3, 4);   // R4: I / M
    do_op(0, 0, 3, 2);   // R6: S / S, penalty
    do_op(0, 1, 3, 0);   // R4 from Shared
    lat = 3;
    do_op(1, 1, 3, 1);   // R7 with peer Modified
    do_op(1, 0, 3, 5);   // R5 read own Modified
    do_op(1, 1, 3, 6);   // R4 write own Modified
    do_op(0, 1, 7, 0);   // R7 write miss, peer Invalid
    do_op(1, 0, 2, 0);   // R2
    do_op(1, 1, 2, 9);   // R4 from Exclusive

    // R8: offsets within one line share state, next line does not
    lat = 1;
    do_op(0, 0, 9, 0);
    do_op(0, 0, 9, 63);
    do_op(0, 0, 10, 0);

    // R10: same-cycle requests to line 5
    begin
      bit h, f;
      string t;
      int a0 = 0, a1 = 0;
      model(0, 0, 5, h, f, t);
      model(1, 0, 5, h, f, t);
      @(negedge clk);
      c0_req = 1; c0_we = 0; c0_addr = {4'd5, 6'd0};
      c1_req = 1; c1_we = 0; c1_addr = {4'd5, 6'd33};
      for (int k = 1; k < 60 && (a0 == 0 || a1 == 0); k++) begin
        @(negedge clk);
        #2;
        chk(!(c0_ack && c1_ack), "R10 single ack", c0_ack + c1_ack, 1);
        if (c0_ack) begin a0 = k; c0_req = 0; end
        if (c1_ack) begin a1 = k; c1_req = 0; end
      end
      chk(a0 != 0 && a0 < a1, "R10 core0 first", a0, a1);
      check_line(5, "R10");
      check_counts("R10");
    end

    // Near-exhaustive pseudo-random sweep over four lines
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lat = 1 + (lf[9:8] % 3);
        do_op(int'(lf[0]), int'(lf[1]), int'(lf[3:2]), int'(lf[15:10]));
      end
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule